// File: doc/BRIEF.md
# Floating-point minimum/maximum unit with selectable NaN policy

This combinational unit takes two single-precision (binary32) operands and returns their minimum or maximum. A three-bit function select picks the operation and the NaN policy for each operation, so no mode register persists between operations. Three policies exist. The NaN-favoring policy returns a NaN whenever either input is a NaN. The number-favoring policy returns the numeric operand when only one input is a NaN. The legacy compare-and-select policy returns the second operand whenever the comparison is false.

In both symmetric policies, two NaN inputs merge into one quiet NaN. Its bits are the bitwise OR of both input words. This keeps error-tracing payload bits from both inputs and gives the same result when the operands are swapped. The legacy policy is asymmetric on purpose: it matches the behaviour of code that spells the comparison out. The `invalid_o` flag marks any signaling NaN input.

Top module: `fpmm_minmax`

## Requirements
- R1: For two non-NaN inputs, codes 000/010 return the smaller and codes 001/011 return the larger value, with -0 (0x80000000) ordered below +0 (0x00000000), and the result is one input word unchanged.
- R2: With codes 000/001, if exactly one input is a NaN (exponent field all ones, fraction non-zero), the result is that NaN with fraction bit 22 (the quiet bit) set and all other bits kept.
- R3: With codes 010/011, if exactly one input is a NaN, the result is the other, numeric input word unchanged.
- R4: With codes 000..011, if both inputs are NaN, the result is the bitwise OR of both input words with bit 22 set.
- R5: Codes 000..011 give a bit-identical result when `a_i` and `b_i` are swapped.
- R6: Legacy min (code 1x0) returns `a_i` if a<b and otherwise `b_i`. Legacy max (code 1x1) returns `a_i` if a>b and otherwise `b_i`. Any comparison involving a NaN is false, and ±0 compare equal. The returned word is never altered, so a signaling NaN in `b_i` passes through unquieted.
- R7: `invalid_o` is 1 exactly when either input is a signaling NaN (a NaN with bit 22 clear), for every select code.
- R8: Select bit 2 chooses legacy, bit 0 chooses max over min, and bit 1 chooses number-favoring over NaN-favoring only when bit 2 is 0. Codes 110 and 111 therefore act as 100 and 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, binary32 |
| b_i | input | 32 | Second operand, binary32 |
| sel_i | input | 3 | Function select |
| res_o | output | 32 | Selected result |
| invalid_o | output | 1 | A signaling NaN was present on an input |

## Verification
The hardest situations to reach are those that only show up with the operands swapped. These are a NaN meeting a number in the legacy policy, a signaling NaN in the second position, two NaNs with disjoint payloads, and the two signed zeros. Random binary32 words almost never hit these cases. The stimulus therefore crosses a hand-picked table of boundary words in every ordered pair under all eight select codes. This table includes both zeros, denormals, infinities, and quiet and signaling NaNs of both signs with distinct payload bits. A random sweep follows, in which the exponent is forced to all ones about a quarter of the time. Every vector in the symmetric codes is applied a second time with the operands swapped.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef struct packed {
    logic nan;
    logic snan;
  } fp_class_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_i,
  output fp_class_t    cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  assign exp_f = op_i[W-2 -: EXP_W];
  assign man_f = op_i[MAN_W-1:0];

  always_comb begin
    cls_o.nan  = (&exp_f) && (|man_f);
    cls_o.snan = cls_o.nan && !man_f[MAN_W-1];
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         a_lt_sym_o,  // total order, -0 < +0
  output logic         a_lt_leg_o,  // zeros equal
  output logic         a_gt_leg_o
);
  logic [W-1:0] key_a, key_b;
  logic         both_zero;

  // sign-magnitude to unsigned order
  assign key_a = a_i[W-1] ? ~a_i : (a_i ^ {1'b1, {(W-1){1'b0}}});
  assign key_b = b_i[W-1] ? ~b_i : (b_i ^ {1'b1, {(W-1){1'b0}}});
  assign both_zero = (a_i[W-2:0] == '0) && (b_i[W-2:0] == '0);

  assign a_lt_sym_o = key_a < key_b;
  assign a_lt_leg_o = !both_zero && (key_a < key_b);
  assign a_gt_leg_o = !both_zero && (key_a > key_b);
endmodule

// File: rtl/fpmm_nan_merge.sv
module fpmm_nan_merge #(
  parameter int W     = 32,
  parameter int MAN_W = 23
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         a_nan_i,
  input  logic         b_nan_i,
  output logic [W-1:0] nan_o
);
  localparam logic [W-1:0] QBIT = W'(1) << (MAN_W - 1);

  // OR of all NaN inputs keeps payload bits from both and is commutative
  assign nan_o = (a_nan_i ? a_i : '0) | (b_nan_i ? b_i : '0) | QBIT;
endmodule

// File: rtl/fpmm_minmax.sv
module fpmm_minmax
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] res_o,
  output logic         invalid_o
);
  fp_class_t  cls [2];
  logic [W-1:0] ops [2];
  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i (ops[g]),
      .cls_o(cls[g])
    );
  end

  logic a_lt_sym, a_lt_leg, a_gt_leg;
  fpmm_order #(.W(W)) u_ord (
    .a_i       (a_i),
    .b_i       (b_i),
    .a_lt_sym_o(a_lt_sym),
    .a_lt_leg_o(a_lt_leg),
    .a_gt_leg_o(a_gt_leg)
  );

  logic [W-1:0] nan_res;
  fpmm_nan_merge #(.W(W), .MAN_W(MAN_W)) u_merge (
    .a_i    (a_i),
    .b_i    (b_i),
    .a_nan_i(cls[0].nan),
    .b_nan_i(cls[1].nan),
    .nan_o  (nan_res)
  );

  logic legacy, want_max, num_fav, any_nan, both_nan;
  logic [W-1:0] sym_res, leg_res;

  assign legacy   = sel_i[2];
  assign want_max = sel_i[0];
  assign num_fav  = sel_i[1] && !legacy;
  assign any_nan  = cls[0].nan || cls[1].nan;
  assign both_nan = cls[0].nan && cls[1].nan;

  always_comb begin
    if (!any_nan)
      sym_res = (want_max ? !a_lt_sym : a_lt_sym) ? a_i : b_i;
    else if (num_fav && !both_nan)
      sym_res = cls[0].nan ? b_i : a_i;
    else
      sym_res = nan_res;
  end

  // NaN makes every comparison false -> second operand
  assign leg_res   = (!any_nan && (want_max ? a_gt_leg : a_lt_leg)) ? a_i : b_i;
  assign res_o     = legacy ? leg_res : sym_res;
  assign invalid_o = cls[0].snan || cls[1].snan;

  always_comb begin
    if (!legacy && !num_fav && any_nan)
      assert_nan_wins_R2: assert (&res_o[W-2 -: EXP_W] && res_o[MAN_W-1])
        else $error("NaN-favoring result not a quiet NaN");
    if (num_fav && (cls[0].nan != cls[1].nan))
      assert_number_wins_R3: assert (res_o == (cls[0].nan ? b_i : a_i))
        else $error("number-favoring did not return numeric operand");
    if (!legacy && both_nan)
      assert_payload_kept_R4: assert ((res_o & (a_i | b_i)) == (a_i | b_i))
        else $error("NaN payload bit lost");
    if (legacy && any_nan)
      assert_legacy_second_R6: assert (res_o == b_i)
        else $error("legacy NaN compare did not return second operand");
    if (!legacy && !any_nan)
      assert_pick_input_R1: assert (res_o == a_i || res_o == b_i)
        else $error("numeric result is not an input");
  end
endmodule

// File: tb/fpmm_minmax_tb.sv
module fpmm_minmax_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] QB = 32'h0040_0000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] a, b, res;
  logic [2:0]  sel;
  logic        inv;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  fpmm_minmax dut_i (
    .a_i(a), .b_i(b), .sel_i(sel), .res_o(res), .invalid_o(inv)
  );

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction
  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction
  function automatic bit is_zero(logic [31:0] x);
    return x[30:0] == 0;
  endfunction
  // strict numeric less-than, -0 below +0
  function automatic bit num_lt(logic [31:0] x, logic [31:0] y);
    if (x[31] != y[31]) return x[31];
    if (!x[31]) return x[30:0] < y[30:0];
    return x[30:0] > y[30:0];
  endfunction

  function automatic logic [31:0] model(logic [2:0] s, logic [31:0] x, logic [31:0] y);
    bit an = is_nan(x), bn = is_nan(y);
    if (s[2]) begin
      if (an || bn || (is_zero(x) && is_zero(y))) return y;
      if (s[0]) return num_lt(y, x) ? x : y;
      return num_lt(x, y) ? x : y;
    end
    if (an && bn) return x | y | QB;
    if (an) return s[1] ? y : (x | QB);
    if (bn) return s[1] ? x : (y | QB);
    if (s[0]) return num_lt(x, y) ? y : x;
    return num_lt(x, y) ? x : y;
  endfunction

  function automatic string req_of(logic [2:0] s, logic [31:0] x, logic [31:0] y);
    if (s[2]) return "R6/R8";
    if (is_nan(x) && is_nan(y)) return "R4";
    if (is_nan(x) || is_nan(y)) return s[1] ? "R3" : "R2";
    return "R1";
  endfunction

  task automatic apply(input logic [2:0] s, input logic [31:0] x, input logic [31:0] y,
                       output logic [31:0] r, output logic v);
    @(posedge clk);
    sel = s; a = x; b = y;
    @(negedge clk);
    r = res; v = inv;
  endtask

  task automatic check_one(input logic [2:0] s, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] r, r2, e;
    logic v, v2, ev;
    e  = model(s, x, y);
    ev = is_snan(x) || is_snan(y);
    apply(s, x, y, r, v);
    n_chk++;
    if (r !== e) begin
      n_fail++;
      $display("FAIL %s sel=%b a=%h b=%h res=%h expected=%h", req_of(s, x, y), s, x, y, r, e);
    end
    n_chk++;
    if (v !== ev) begin
      n_fail++;
      $display("FAIL R7 sel=%b a=%h b=%h invalid=%b expected=%b", s, x, y, v, ev);
    end
    if (!s[2]) begin
      apply(s, y, x, r2, v2);
      n_chk++;
      if (r2 !== r) begin
        n_fail++;
        $display("FAIL R5 sel=%b a=%h b=%h swapped=%h expected=%h", s, x, y, r2, r);
      end
    end
  endtask

  logic [31:0] tbl [24];

  initial begin
    tbl[0]  = 32'h0000_0000; tbl[1]  = 32'h8000_0000;
    tbl[2]  = 32'h0000_0001; tbl[3]  = 32'h8000_0001;
    tbl[4]  = 32'h3f80_0000; tbl[5]  = 32'hbf80_0000;
    tbl[6]  = 32'h4000_0000; tbl[7]  = 32'hc000_0000;
    tbl[8]  = 32'h7f7f_ffff; tbl[9]  = 32'hff7f_ffff;
    tbl[10] = 32'h7f80_0000; tbl[11] = 32'hff80_0000;
    tbl[12] = 32'h7fc0_0000; tbl[13] = 32'h7fc0_0001;
    tbl[14] = 32'h7fc0_0100; tbl[15] = 32'hffc0_0010;
    tbl[16] = 32'h7f80_0001; tbl[17] = 32'h7fa0_0000;
    tbl[18] = 32'hff80_0200; tbl[19] = 32'h007f_ffff;
    tbl[20] = 32'h0080_0000; tbl[21] = 32'h3f80_0001;
    tbl[22] = 32'hbf7f_ffff; tbl[23] = 32'h4120_0000;
  end

  initial begin
    logic [31:0] lfsr, x, y;
    a = '0; b = '0; sel = '0;
    lfsr = 32'h1357_9bdf;
    repeat (2) @(posedge clk);
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 24; i++)
        for (int j = 0; j < 24; j++)
          check_one(3'(s), tbl[i], tbl[j]);
    for (int k = 0; k < 1200; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr ^ (lfsr << 7);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      y = lfsr ^ (lfsr >> 5);
      if (x[1:0] == 2'b00) x[30:23] = 8'hff;
      if (y[3:2] == 2'b00) y[30:23] = 8'hff;
      check_one(3'(k % 8), x, y);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule